// File: doc/BRIEF.md
# Pseudo-SRAM Page-Mode Controller

This block sits between a clocked host and an asynchronous pseudo-static RAM with a 16-bit data bus, 21-bit word addresses, two chip selects (one active-low, one active-high), an active-low output enable, an active-low write enable and two active-low byte-lane enables. It accepts three kinds of host request: a single-word read, a single-word write with a two-bit byte mask, and a four-word page read. Every nanosecond limit of the memory is a parameter, and the controller turns each into a clock-cycle count by dividing by the clock period and rounding up. With the default 20 ns clock: read 4 cycles, page word 2 cycles, write 4 cycles (write strobe 3), long write 5 cycles (strobe 4), deselect gap 4 cycles, power-up hold 10000 cycles.

Requests arrive on a valid/ready port. A request is taken on a clock edge where `req_valid` and `req_ready` are both high; `req_ready` never depends on `req_valid`, and the host must hold the request steady until it is taken. Read words leave on a valid/ready response port. A word stays on `rsp_data` with `rsp_valid` high until an edge where `rsp_ready` is high. While a word waits, the controller does not sample the next word. It keeps the memory address and strobes steady until the host drains the response.

The data bus is split into an output word, an output enable and an input word, so the tristate pad stays outside this block. The controller drives the bus only during write cycles, and it always leaves one released cycle before it asserts the output enable.

Top module: `psram_ctl`

## Requirements
- R1: After reset, for at least the power-up count (10000 cycles by default), the active-low chip select stays high, the active-high chip select stays low and `req_ready` stays low.
- R2: A request with op 0 or op 3 is a single read of `req_addr`. The read cycle lasts RD_CYC cycles (4 by default). The output enable is high in the first cycle and low after that. `rsp_valid` rises RD_CYC edges after the accepting edge, and `rsp_data` then holds the addressed word.
- R3: A request with op 1 is a write lasting WC_CYC cycles (4 by default). The write enable is low in the last WP_CYC of them (3 by default). `req_be[1]` enables bits 15:8 through the upper-lane pin and `req_be[0]` enables bits 7:0 through the lower-lane pin. A disabled lane keeps its old memory content. Address and write data stay stable while the write enable is low.
- R4: Writes taken back-to-back form a run. The 51st write of a run and every later one uses the long timing: 5 cycles, with the write enable low for 4. Any read or any idle cycle ends the run, and the next write uses the short timing again.
- R5: A request with op 2 is a page read. Address bits 20:2 come from `req_addr` and bits 1:0 are ignored. The controller returns the words at low bits 0, 1, 2 and 3 in that order. The first word arrives RD_CYC edges after acceptance and each later word PG_CYC edges (2 by default) after the one before, while `rsp_ready` is high.
- R6: After the last word of a page read is sampled, the memory stays deselected and `req_ready` stays low for RC_CYC cycles (4 by default).
- R7: The data bus is driven only during write cycles and never while the output enable is low. The bus is released in the cycle before the output enable falls.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` stay unchanged. The controller holds the current memory address and loses no page word.
- R9: `req_ready` is high in the idle state after power-up and in the last cycle of a write. It is low in every other cycle of an access.
- R10: Whenever the output enable is low, both byte lanes are enabled and the write enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be taken this edge |
| req_op | input | 2 | 0 read, 1 write, 2 page read, 3 read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Write byte mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | Read word present |
| rsp_ready | input | 1 | Host takes the read word |
| rsp_data | output | 16 | Read word |
| mem_addr | output | 21 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Data read from the bus |

## Verification
A single read's word is due exactly RD_CYC edges after the accepting edge. Page words follow every PG_CYC edges, write strobes last WP_CYC cycles (or four in a long run), and the deselect gap lasts RC_CYC cycles. The bench counts edges from the accepting edge and samples one time step after each edge, then compares the count with these values. The memory model returns valid data only once the address has been steady long enough at the output enable, so a read sampled one cycle early yields a poison word. Write strobe widths are measured on the pin, and a gap or a read between runs shows that the long timing resets.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PAGE  = 2'd2,
    OP_READ2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_COOL
  } st_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_powerup.sv
module psram_powerup #(
  parameter int unsigned PU_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic up
);
  localparam int unsigned W = $clog2(PU_CYC + 2);

  logic [W-1:0] cnt;

  assign up = (cnt == W'(PU_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (!up) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/psram_streak.sv
module psram_streak #(
  parameter int unsigned LONG_AFTER = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk,
  input  logic wr_start,
  output logic long_next
);
  localparam int unsigned SW = $clog2(LONG_AFTER + 2);

  logic [SW-1:0] cnt;
  logic [SW-1:0] base;

  assign base      = brk ? '0 : cnt;
  assign long_next = (base >= SW'(LONG_AFTER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_start) begin
      cnt <= (base == SW'(LONG_AFTER + 1)) ? base : base + 1'b1;
    end else if (brk) begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/psram_rsp_reg.sv
module psram_rsp_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          busy
);
  assign busy = rsp_valid && !rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= din;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/psram_ctl.sv
module psram_ctl
  import psram_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned AW           = 21,
  parameter int unsigned CLK_NS       = 20,
  parameter int unsigned T_PU_NS      = 200000,
  parameter int unsigned T_RC_NS      = 70,
  parameter int unsigned T_AA_NS      = 70,
  parameter int unsigned T_OE_NS      = 35,
  parameter int unsigned T_PC_NS      = 25,
  parameter int unsigned T_PA_NS      = 20,
  parameter int unsigned T_WC_NS      = 70,
  parameter int unsigned T_WP_NS      = 55,
  parameter int unsigned T_DW_NS      = 30,
  parameter int unsigned T_WC_LONG_NS = 90,
  parameter int unsigned T_WP_LONG_NS = 70,
  parameter int unsigned LONG_AFTER   = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs1_n,
  output logic          mem_cs2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  // cycle counts, always rounded up
  localparam int unsigned PU_CYC  = ns_to_cyc(T_PU_NS, CLK_NS);
  localparam int unsigned RC_CYC  = umax(ns_to_cyc(T_RC_NS, CLK_NS), 1);
  localparam int unsigned RD_CYC  = umax(umax(RC_CYC, ns_to_cyc(T_AA_NS, CLK_NS)),
                                         1 + ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned PG_CYC  = umax(umax(ns_to_cyc(T_PC_NS, CLK_NS),
                                              ns_to_cyc(T_PA_NS, CLK_NS)), 1);
  localparam int unsigned WP_CYC  = umax(ns_to_cyc(T_WP_NS, CLK_NS), 1);
  localparam int unsigned WC_CYC  = umax(umax(ns_to_cyc(T_WC_NS, CLK_NS), WP_CYC + 1),
                                         ns_to_cyc(T_DW_NS, CLK_NS));
  localparam int unsigned WPL_CYC = umax(ns_to_cyc(T_WP_LONG_NS, CLK_NS), WP_CYC);
  localparam int unsigned WCL_CYC = umax(umax(ns_to_cyc(T_WC_LONG_NS, CLK_NS), WPL_CYC + 1),
                                         WC_CYC);
  localparam int unsigned CW      = $clog2(umax(umax(RD_CYC, WCL_CYC),
                                                umax(RC_CYC, PG_CYC)) + 1);

  st_e           st;
  logic [CW-1:0] cnt;
  logic [1:0]    word;
  logic          page_q;
  logic          long_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    be_q;

  logic          up;
  logic          long_next;
  logic          rsp_busy;
  logic [CW-1:0] word_len;
  logic [CW-1:0] wc_len;
  logic [CW-1:0] wp_len;
  logic          rd_end;
  logic          sample;
  logic          last_word;
  logic          wr_last;
  logic          acc;
  logic          acc_wr;
  logic          acc_rd;
  logic          brk;

  psram_powerup #(.PU_CYC(PU_CYC)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .up    (up)
  );

  psram_streak #(.LONG_AFTER(LONG_AFTER)) u_streak (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk       (brk),
    .wr_start  (acc_wr),
    .long_next (long_next)
  );

  psram_rsp_reg #(.DW(DW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sample),
    .din       (mem_dq_in),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .busy      (rsp_busy)
  );

  assign word_len  = (word == 2'd0) ? CW'(RD_CYC) : CW'(PG_CYC);
  assign wc_len    = long_q ? CW'(WCL_CYC) : CW'(WC_CYC);
  assign wp_len    = long_q ? CW'(WPL_CYC) : CW'(WP_CYC);
  assign rd_end    = (st == ST_RD) && (cnt == word_len - 1'b1);
  assign sample    = rd_end && !rsp_busy;
  assign last_word = !page_q || (word == 2'd3);
  assign wr_last   = (st == ST_WR) && (cnt == wc_len - 1'b1);

  assign req_ready = (st == ST_IDLE) || wr_last;
  assign acc       = req_valid && req_ready;
  assign acc_wr    = acc && (req_op == OP_WRITE);
  assign acc_rd    = acc && (req_op != OP_WRITE);
  assign brk       = (st == ST_IDLE) || acc_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PWR;
      cnt     <= '0;
      word    <= '0;
      page_q  <= 1'b0;
      long_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      unique case (st)
        ST_PWR: begin
          if (up) st <= ST_IDLE;
        end
        ST_IDLE, ST_WR: begin
          if (acc) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            page_q  <= (req_op == OP_PAGE);
            long_q  <= long_next;
            cnt     <= '0;
            word    <= '0;
            st      <= acc_wr ? ST_WR : ST_RD;
          end else if (st == ST_WR) begin
            if (wr_last) st <= ST_IDLE;
            else         cnt <= cnt + 1'b1;
          end
        end
        ST_RD: begin
          if (sample) begin
            cnt <= '0;
            if (last_word) st <= page_q ? ST_COOL : ST_IDLE;
            else           word <= word + 1'b1;
          end else if (!rd_end) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_COOL: begin
          if (cnt == CW'(RC_CYC - 1)) begin
            cnt <= '0;
            st  <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_cs1_n  = !((st == ST_RD) || (st == ST_WR));
  assign mem_cs2    = (st != ST_PWR);
  assign mem_addr   = {addr_q[AW-1:2], page_q ? word : addr_q[1:0]};
  assign mem_oe_n   = !((st == ST_RD) && ((cnt != '0) || (word != 2'd0)));
  assign mem_we_n   = !((st == ST_WR) && (cnt >= wc_len - wp_len));
  assign mem_ub_n   = (st == ST_WR) ? !be_q[1] : (st != ST_RD);
  assign mem_lb_n   = (st == ST_WR) ? !be_q[0] : (st != ST_RD);
  assign mem_dq_oe  = (st == ST_WR);
  assign mem_dq_out = wdata_q;

endmodule

// File: rtl/psram_ctl_chk.sv
module psram_ctl_chk #(
  parameter int unsigned DW     = 16,
  parameter int unsigned AW     = 21,
  parameter int unsigned PU_CYC = 10000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic [1:0]    req_be,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [AW-1:0] mem_addr,
  input logic          mem_cs1_n,
  input logic          mem_cs2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic [DW-1:0] mem_dq_in
);
  localparam int unsigned SW = $clog2(PU_CYC + 2);

  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   since <= '0;
    else if (since != SW'(PU_CYC)) since <= since + 1'b1;
  end

  // R1
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since < SW'(PU_CYC)) |-> (mem_cs1_n && !mem_cs2 && !req_ready));

  // R7
  bus_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R7
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  // R3
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_dq_oe));

  // R3
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  // R10
  rd_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ub_n && !mem_lb_n && mem_we_n));

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

bind psram_ctl psram_ctl_chk #(.DW(DW), .AW(AW), .PU_CYC(PU_CYC)) u_chk (.*);

// File: tb/psram_ctl_bench.sv
module psram_ctl_bench;

  localparam int CLK_NS  = 20;
  localparam int PU_CYC  = (200000 + CLK_NS - 1) / CLK_NS;
  localparam int AA_CYC  = (70 + CLK_NS - 1) / CLK_NS;
  localparam int PA_CYC  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int RD_CYC  = 4;
  localparam int PG_CYC  = 2;
  localparam int RC_CYC  = 4;
  localparam int WP_CYC  = 3;
  localparam int WPL_CYC = 4;

  typedef struct packed {
    logic [1:0]  op;
    logic [20:0] addr;
    logic [15:0] data;
    logic [1:0]  be;
    logic [15:0] expv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 21'h000010, 16'hA1B2, 2'b11, 16'h0000},
    '{2'd1, 21'h000011, 16'hC3D4, 2'b11, 16'h0000},
    '{2'd1, 21'h000010, 16'h55EE, 2'b01, 16'h0000},
    '{2'd1, 21'h000011, 16'h7788, 2'b10, 16'h0000},
    '{2'd0, 21'h000010, 16'h0000, 2'b00, 16'hA1EE},
    '{2'd0, 21'h000011, 16'h0000, 2'b00, 16'h77D4},
    '{2'd1, 21'h000012, 16'hFFFF, 2'b00, 16'h0000},
    '{2'd0, 21'h000012, 16'h0000, 2'b00, 16'h1212},
    '{2'd3, 21'h1F0005, 16'h0000, 2'b00, 16'h0505}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_data;
  logic [20:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_NS / 2) clk = ~clk;

  psram_ctl u_psram_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
    .mem_lb_n(mem_lb_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // memory model, strobe monitors
  logic [15:0] mem [256];
  int          age_hi, age_lo;
  logic        p_we_n, p_ub, p_lb;
  logic [20:0] p_addr;
  logic [15:0] p_d;
  int          bus_bad = 0;
  int          lane_bad = 0;
  int          pl [64];
  int          pcount = 0;
  int          lowrun = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = {i[7:0], i[7:0]};
      age_hi = 0; age_lo = 0; p_we_n = 1'b1; p_ub = 1'b1; p_lb = 1'b1;
      p_addr = '0; p_d = '0; mem_dq_in = 16'hBAD0;
    end else begin
      if (!p_we_n && mem_we_n) begin
        if (!p_ub) mem[p_addr[7:0]][15:8] = p_d[15:8];
        if (!p_lb) mem[p_addr[7:0]][7:0]  = p_d[7:0];
      end
      if (mem_cs1_n || !mem_cs2 || !mem_we_n || mem_addr[20:2] != p_addr[20:2]) age_hi = 0;
      else age_hi++;
      if (mem_addr[1:0] != p_addr[1:0]) age_lo = 0;
      else age_lo++;
      if (!mem_cs1_n && mem_cs2 && !mem_oe_n && mem_we_n &&
          age_hi >= AA_CYC - 1 && age_lo >= PA_CYC - 1)
        mem_dq_in = mem[mem_addr[7:0]];
      else
        mem_dq_in = 16'hBAD0;
      if (mem_dq_oe && !mem_oe_n) bus_bad++;
      if (!mem_oe_n && (mem_ub_n || mem_lb_n)) lane_bad++;
      if (!mem_we_n) lowrun++;
      else if (lowrun != 0) begin
        if (pcount < 64) pl[pcount] = lowrun;
        pcount++;
        lowrun = 0;
      end
      p_we_n = mem_we_n; p_ub = mem_ub_n; p_lb = mem_lb_n;
      p_addr = mem_addr; p_d = mem_dq_out;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    bit r;
    req_op = op; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
    forever begin
      r = req_ready;
      @(posedge clk);
      if (r) break;
      #1;
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output logic [15:0] d, output int edges);
    edges = 0;
    forever begin
      @(posedge clk);
      edges++;
      #1;
      if (rsp_valid || edges > 100) break;
    end
    d = rsp_data;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int e, n, pb;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(mem_cs1_n && !mem_cs2 && !req_ready && !rsp_valid && !mem_dq_oe, "R1 reset state",
        {mem_cs1_n, mem_cs2, req_ready}, 32'h4);
    rst_n = 1'b1;
    n = 0;
    while (!req_ready && n < 20000) begin
      if (!mem_cs1_n || mem_cs2) begin
        chk(0, "R1 deselect during power-up", {mem_cs1_n, mem_cs2}, 2'b10);
      end
      @(posedge clk); #1; n++;
    end
    chk(n >= PU_CYC && n < PU_CYC + 4, "R1 power-up hold", n, PU_CYC);
    chk(mem_cs2 && mem_cs1_n, "R1 idle after power-up", {mem_cs2, mem_cs1_n}, 2'b11);

    // vector table: writes then reads with byte masks
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].be);
      if (VEC[i].op != 2'd1) begin
        wait_rsp(d, e);
        chk(d == VEC[i].expv, "R2/R3 read data", d, VEC[i].expv);
        chk(e == RD_CYC, "R2 read latency", e, RD_CYC);
      end
    end

    // R9 ready low mid-write, high in last write cycle
    send(2'd1, 21'h20, 16'h1357, 2'b11);
    chk(!req_ready, "R9 ready low in write", req_ready, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready, "R9 ready in last write cycle", req_ready, 1);
    @(posedge clk); #1;

    // R5 page read, low bits ignored, R6 deselect gap
    send(2'd2, 21'h000036, 16'h0, 2'b00);
    for (int w = 0; w < 4; w++) begin
      wait_rsp(d, e);
      chk(d == {8'h34 + 8'(w), 8'h34 + 8'(w)}, "R5 page word", d, {8'h34 + 8'(w), 8'h34 + 8'(w)});
      chk(e == ((w == 0) ? RD_CYC : PG_CYC), "R5 page spacing", e, (w == 0) ? RD_CYC : PG_CYC);
    end
    n = 0;
    while (!req_ready && n < 50) begin
      if (!mem_cs1_n) chk(0, "R6 chip selected in gap", mem_cs1_n, 1);
      n++; @(posedge clk); #1;
    end
    chk(n == RC_CYC, "R6 deselect gap", n, RC_CYC);

    // R8 response back-pressure during a page read
    rsp_ready = 1'b0;
    send(2'd2, 21'h1F0058, 16'h0, 2'b00);
    repeat (20) @(posedge clk);
    #1;
    chk(rsp_valid && rsp_data == 16'h5858, "R8 word held", rsp_data, 16'h5858);
    chk(mem_addr[1:0] == 2'd1 && !mem_cs1_n, "R8 address held", mem_addr[1:0], 1);
    d = rsp_data;
    rsp_ready = 1'b1;
    for (int w = 1; w < 4; w++) begin
      wait_rsp(d, e);
      chk(d == {8'h58 + 8'(w), 8'h58 + 8'(w)}, "R8 page word after stall", d,
          {8'h58 + 8'(w), 8'h58 + 8'(w)});
    end
    repeat (6) @(posedge clk);
    #1;

    // R4 long timing after 50 back-to-back writes
    pb = pcount;
    for (int k = 0; k < 52; k++) send(2'd1, 21'h80 + 21'(k), 16'h5A00 + 16'(k), 2'b11);
    repeat (8) @(posedge clk);
    #1;
    for (int k = 0; k < 52; k++) begin
      chk(pl[pb + k] == ((k < 50) ? WP_CYC : WPL_CYC), "R4 strobe width",
          pl[pb + k], (k < 50) ? WP_CYC : WPL_CYC);
    end
    send(2'd0, 21'h80 + 21'd51, 16'h0, 2'b00);
    wait_rsp(d, e);
    chk(d == 16'h5A33, "R4 long write data", d, 16'h5A33);
    pb = pcount;
    send(2'd1, 21'h21, 16'h2468, 2'b11);
    repeat (6) @(posedge clk);
    #1;
    chk(pl[pb] == WP_CYC, "R4 run reset by read", pl[pb], WP_CYC);

    // R7 / R10 monitors
    chk(bus_bad == 0, "R7 bus driven with output enable", bus_bad, 0);
    chk(lane_bad == 0, "R10 read lanes", lane_bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule